// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC and decides, frame by frame, whether to keep an incoming frame based on its 48-bit destination address. The address arrives one byte per valid cycle, the first byte on the wire first. While the bytes stream in, the block runs a reflected CRC-32 over them and compares them against a programmed station address. After the sixth byte it gives a one-cycle verdict.

Unicast frames pass only on an exact station-address match. For multicast frames, the top six bits of the CRC pick one bit of a 64-bit hash filter, and the frame passes when that bit is set. The broadcast address always passes. A promiscuous mode accepts every frame, and a receive-enable bit can block every frame.

Software programs the block through a small byte-wide register port. It opens an update window aimed at either the station address or the hash filter, then streams bytes into a data register.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0. Receive is disabled, promiscuous mode is off, the hash filter is all zero and the station address is all zero.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that captures the sixth address byte.
  - A byte taken with `frm_start` high is byte 0 and discards any partly received address.
  - Idle cycles between bytes are allowed.
  - Bytes after the sixth, up to the next `frm_start`, produce no verdict.
- R3: The hash index is computed as follows.
  - The CRC starts at 0xFFFFFFFF.
  - Each byte is shifted in least significant bit first with the reflected polynomial 0xEDB88320.
  - The final CRC is not inverted, and its bits [31:26] form the index i.
  - Index i selects filter bit i: filter byte i/8, bit i%8. Equivalently, 16-bit word i[5:4], bit i[3:0].
- R4: A frame whose first byte has bit 0 set (multicast) is accepted exactly when the indexed filter bit is 1.
  - A filter of all ones accepts every multicast address.
  - A filter of all zeros rejects every multicast address except broadcast.
- R5: The broadcast address FF:FF:FF:FF:FF:FF is accepted whenever receive is enabled, whatever the filter holds.
- R6: A frame whose first byte has bit 0 clear (unicast) is accepted only when all 48 bits equal the station address. Station byte k is compared with address byte k.
- R7: With receive enabled and promiscuous mode on, every frame is accepted.
- R8: With receive disabled, every verdict is reject, including when promiscuous mode is on.
- R9: The register port is written with `cfg_we` high and uses three addresses.
  - Address 0 is control: bit 0 enables receive, bit 1 enables promiscuous mode.
  - Address 1 opens or closes an update: bit 0 opens it, and bit 1 selects the hash filter (1) or the station address (0). A write here also resets the byte pointer to 0.
  - Address 2 is the data port. Each write stores a byte at the pointer and advances it. Station bytes 0..5 and filter bytes 0..7 are stored; any further writes are dropped.
  - Data-port writes while the update is closed are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 control, 1 update, 2 data) |
| cfg_wdata | input | 8 | Register write data |
| frm_start | input | 1 | Marks the first address byte of a new frame |
| addr_valid | input | 1 | `addr_byte` holds an address byte this cycle |
| addr_byte | input | 8 | Destination address byte, first byte first |
| dec_valid | output | 1 | Verdict strobe, one cycle |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject; meaningful with `dec_valid` |

## Verification
The verdict for a frame is due exactly one cycle after the edge that captures its sixth byte, so it shows up at the falling edge that follows that capture. The driver stamps each expected verdict with its due cycle when it drives the sixth byte. The monitor compares both the value and the arrival cycle, and it flags any strobe that arrives with nothing expected, which covers aborted frames and trailing bytes. Register writes take effect on the edge that captures them, so each check sends its frame only after the configuring write has completed.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          AW       = 2,
  parameter int          NSTA     = 6,
  parameter int          NFILT    = 8,
  parameter logic [31:0] POLY     = 32'hEDB88320,
  parameter logic [31:0] CRC_INIT = 32'hFFFFFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          frm_start,
  input  logic          addr_valid,
  input  logic [7:0]    addr_byte,
  output logic          dec_valid,
  output logic          dec_accept
);
  localparam int FBITS = NFILT * 8;
  localparam int IW    = $clog2(FBITS);
  localparam int PW    = $clog2(NFILT + 1);
  localparam int CW    = $clog2(NSTA + 1);

  logic             rx_en, prom, upd_en, upd_log;
  logic [PW-1:0]    ptr;
  logic [NSTA*8-1:0] sta;
  logic [FBITS-1:0] filt;
  logic [CW-1:0]    cnt;
  logic [31:0]      crc;
  logic             match, bcast, mcast;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int j = 0; j < 8; j++)
      r = r[0] ^ b[j] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0; prom <= 1'b0; upd_en <= 1'b0; upd_log <= 1'b0;
      ptr <= '0; sta <= '0; filt <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0): begin rx_en <= cfg_wdata[0]; prom <= cfg_wdata[1]; end
        AW'(1): begin upd_en <= cfg_wdata[0]; upd_log <= cfg_wdata[1]; ptr <= '0; end
        AW'(2): if (upd_en) begin
          if (upd_log && ptr < PW'(NFILT)) filt[ptr*8 +: 8] <= cfg_wdata;
          if (!upd_log && ptr < PW'(NSTA)) sta[ptr*8 +: 8] <= cfg_wdata;
          if (ptr < PW'(NFILT)) ptr <= ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  wire          take   = addr_valid && (frm_start || cnt < CW'(NSTA));
  wire [CW-1:0] k      = frm_start ? '0 : cnt;
  wire [31:0]   crc_nx = crc_byte(frm_start ? CRC_INIT : crc, addr_byte);
  wire          mat_nx = (frm_start || match) && (addr_byte == sta[k*8 +: 8]);
  wire          bc_nx  = (frm_start || bcast) && (addr_byte == 8'hFF);
  wire          mc_nx  = (k == '0) ? addr_byte[0] : mcast;
  wire          last   = take && (k == CW'(NSTA - 1));
  wire [IW-1:0] hidx   = crc_nx[31 -: IW];
  wire          pass   = prom || (mc_nx ? (bc_nx || filt[hidx]) : mat_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= CW'(NSTA); crc <= CRC_INIT;
      match <= 1'b0; bcast <= 1'b0; mcast <= 1'b0;
      dec_valid <= 1'b0; dec_accept <= 1'b0;
    end else begin
      if (take) begin
        cnt <= k + 1'b1; crc <= crc_nx;
        match <= mat_nx; bcast <= bc_nx; mcast <= mc_nx;
      end else if (frm_start) begin
        cnt <= '0; crc <= CRC_INIT;
      end
      dec_valid  <= last;
      dec_accept <= last && rx_en && pass;
    end
  end
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk #(parameter int PW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic          rx_en,
  input logic          prom,
  input logic [PW-1:0] ptr
);
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |=> !dec_valid) else $error("dec_valid held"); // R2
  AST_DEC_SRC: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |-> $past(addr_valid)) else $error("verdict without byte"); // R2
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n) (dec_valid && !$past(rx_en)) |-> !dec_accept) else $error("accept while rx off"); // R8
  AST_PROM_ALL: assert property (@(posedge clk) disable iff (!rst_n) (dec_valid && $past(rx_en && prom)) |-> dec_accept) else $error("promisc reject"); // R7
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ptr <= PW'(8)) else $error("pointer overrun"); // R9
endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .rx_en(rx_en), .prom(prom), .ptr(ptr)
);

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
  logic frm_start = 0, addr_valid = 0; logic [7:0] addr_byte = 0;
  logic dec_valid, dec_accept;

  mcast_hash_filter dut (.*);

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model state, kept from the requirements
  bit m_rx, m_prom, m_upd, m_log; int m_ptr;
  logic [7:0] m_sta [6]; logic [63:0] m_filt;

  bit exp_acc[$]; int exp_due[$]; string exp_tag[$];

  function automatic logic [31:0] ref_crc(logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int n = 0; n < 48; n++) begin
      logic in_bit;
      in_bit = a[47 - 8*(n/8) - 7 + (n%8)];
      if (c[0] != in_bit) c = {1'b0, c[31:1]} ^ 32'hEDB88320;
      else c = {1'b0, c[31:1]};
    end
    return c;
  endfunction

  function automatic bit model_accept(logic [47:0] a);
    bit uni_ok = 1;
    logic [5:0] i;
    if (!m_rx) return 0;
    if (m_prom) return 1;
    if (a == '1) return 1;
    if (a[40]) begin i = ref_crc(a) >> 26; return m_filt[i]; end
    for (int k = 0; k < 6; k++) if (a[47-8*k -: 8] != m_sta[k]) uni_ok = 0;
    return uni_ok;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
    case (a)
      2'd0: begin m_rx = d[0]; m_prom = d[1]; end
      2'd1: begin m_upd = d[0]; m_log = d[1]; m_ptr = 0; end
      2'd2: if (m_upd) begin
        if (m_log && m_ptr < 8) m_filt[m_ptr*8 +: 8] = d;
        if (!m_log && m_ptr < 6) m_sta[m_ptr] = d;
        if (m_ptr < 8) m_ptr++;
      end
      default: ;
    endcase
  endtask

  task automatic set_filt(logic [63:0] f);
    wr(1, 8'h03); for (int k = 0; k < 8; k++) wr(2, f[k*8 +: 8]); wr(1, 8'h00);
  endtask

  task automatic set_sta(logic [47:0] s);
    wr(1, 8'h01); for (int k = 0; k < 6; k++) wr(2, s[47-8*k -: 8]); wr(1, 8'h00);
  endtask

  task automatic send(logic [47:0] a, string tag, bit gap = 0);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      addr_valid = 1; frm_start = (k == 0); addr_byte = a[47-8*k -: 8];
      if (k == 5) begin exp_acc.push_back(model_accept(a)); exp_due.push_back(cyc + 1); exp_tag.push_back(tag); end
      if (gap && k < 5) begin @(posedge clk); #1; addr_valid = 0; frm_start = 0; end
    end
    @(posedge clk); #1; addr_valid = 0; frm_start = 0;
    repeat (2) @(posedge clk);
  endtask

  always @(negedge clk) if (rst_n && dec_valid) begin
    if (exp_acc.size() == 0) check("R2 unexpected verdict", 1, 0);
    else begin
      string t; bit e; int d;
      e = exp_acc.pop_front(); d = exp_due.pop_front(); t = exp_tag.pop_front();
      check({t, " accept"}, dec_accept, e);
      check("R2 verdict cycle", cyc, d);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++; $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  logic [47:0] ma, mb, st;
  initial begin
    m_rx = 0; m_prom = 0; m_upd = 0; m_log = 0; m_ptr = 0; m_filt = '0;
    for (int k = 0; k < 6; k++) m_sta[k] = 8'h00;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check("R1 dec_valid reset", dec_valid, 0);
    check("R1 dec_accept reset", dec_accept, 0);
    send(48'h000000000000, "R1 R8 rx off at reset, station zero");
    send('1, "R8 broadcast rx off");
    wr(0, 8'h01);
    send('1, "R5 broadcast zero filter");
    send(48'h0000_0000_0000, "R1 station zero after reset");
    ma = 48'h01005E0000FB; mb = 48'h3333000000AA;
    send(ma, "R4 mcast zero filter");
    set_filt('1);
    send(ma, "R4 mcast all-ones filter");
    send(mb, "R4 mcast all-ones filter 2");
    begin
      logic [5:0] i; i = ref_crc(ma) >> 26;
      set_filt(64'd1 << i);
      send(ma, "R3 single hash bit hit");
      send(mb, "R3 single hash bit other");
      send(48'h01005E0000FC, "R3 neighbour address");
    end
    send('1, "R5 broadcast sparse filter");
    st = 48'h02A1B2C3D4E5;
    set_sta(st);
    send(st, "R6 exact station match", 1);
    send(st ^ 48'h1, "R6 last bit differs");
    send(st ^ 48'h020000000000, "R6 first byte differs");
    wr(2, 8'h55); wr(2, 8'h66);
    send(st, "R9 data write with update closed");
    wr(1, 8'h01); for (int k = 0; k < 8; k++) wr(2, 8'hA0 + 8'(k)); wr(1, 8'h00);
    send(48'hA0A1A2A3A4A5, "R9 station from first six writes");
    set_sta(st);
    wr(1, 8'h03); wr(2, 8'h00); wr(1, 8'h00);
    send(st, "R9 filter target leaves station");
    send(ma, "R9 filter byte 0 rewritten");
    wr(0, 8'h03);
    send(48'h020000000001, "R7 promisc unicast miss");
    send(48'h0100000000AB, "R7 promisc multicast");
    wr(0, 8'h02);
    send(st, "R8 promisc but rx off");
    wr(0, 8'h01);
    // aborted frame then restart
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1; addr_valid = 1; frm_start = (k == 0); addr_byte = 8'hFF;
    end
    @(posedge clk); #1; addr_valid = 0; frm_start = 0;
    send(st ^ 48'h10, "R2 restart after abort");
    // trailing bytes make no verdict
    for (int k = 0; k < 4; k++) begin @(posedge clk); #1; addr_valid = 1; addr_byte = 8'hFF; end
    @(posedge clk); #1; addr_valid = 0;
    // random filter sweep
    set_filt({$urandom, $urandom});
    for (int n = 0; n < 16; n++) send({$urandom, 16'($urandom)} | 48'h010000000000, "R3 R4 random multicast");
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R2 all verdicts arrived", exp_acc.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule